// File: doc/BRIEF.md
# Half-Bridge Gate Interlock and Fault Controller

This block is the synchronous decision logic between two logic-level gate commands, one for the low-side switch and one for the high-side switch of a half-bridge, and the two gate-enable outputs that drive the power stages. Its other inputs are digitised comparator flags for each side: overcurrent or desaturation, a positive supply that is too low, and a negative supply that is not negative enough. A returned status bit reports a fault on the high side. All of these inputs are asynchronous. Each one passes through a two-flop synchroniser before any decision uses it.

Each side keeps its own overcurrent latch. The latch samples the sense flag only while that side's gate is on and a blanking window after the command's rising edge has ended. The next rising edge of that side's command clears the latch. An undervoltage holds its side off only while the condition lasts. An interlock refuses to turn either side on while the opposite command is high. The block combines every fault condition into one open-drain pull-down enable for a shared active-low fault line.

Top module: `hb_gate_guard`

## Requirements
- R1: With no fault on its side and the opposite command low, a gate enable follows its own command (1 = gate on). A low command turns the gate off. The output changes three clock edges after the raw input changes.
- R2: While a gate is on and its blanking window has ended, a high overcurrent flag turns that gate off within TRIP_MAX_CYC clock cycles of the raw flag rising. It also sets flt_pull_o to 1.
- R3: While a side's gate is off, its overcurrent flag is ignored. The flag neither latches a fault nor sets flt_pull_o.
- R4: An overcurrent fault stays latched after the flag clears and after the command falls. Only the next rising edge of that side's command releases it.
- R5: For BLANK_CYC sampling edges after a command's rising edge, that side's overcurrent flag is ignored.
- R6: When a command rising edge and an overcurrent flag reach the logic on the same edge, the latch is cleared and the gate turns on. A flag that is still high trips the gate once blanking ends.
- R7: A side with its positive-supply-low flag or its negative-supply-high flag at 1 has its gate held off and flt_pull_o at 1. Both release as soon as the flag returns to 0, with no command edge needed.
- R8: After reset both gates are off and flt_pull_o is 1. A gate cannot turn on until both supply flags of its side have been seen at 0.
- R9: flt_pull_o is 1 whenever either side has a fault or the returned high-side status bit is 1, and 0 otherwise. A high-side fault or status bit never turns off the low-side gate.
- R10: A side that is off does not turn on while the opposite command is high. A side that is already on stays on when the opposite command rises.
- R11: If both commands rise on the same edge, both gates stay off until one command falls. The other side may then turn on.
- R12: gate_lo_o and gate_hi_o are never 1 at the same time, under any input or fault sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_lo_i | input | 1 | Low-side gate command, asynchronous, 1 = on |
| cmd_hi_i | input | 1 | High-side gate command, asynchronous, 1 = on |
| oc_lo_i | input | 1 | Low-side overcurrent or desaturation flag |
| oc_hi_i | input | 1 | High-side overcurrent or desaturation flag |
| uvp_lo_i | input | 1 | Low-side positive supply below trip |
| uvn_lo_i | input | 1 | Low-side negative supply above trip |
| uvp_hi_i | input | 1 | High-side positive supply below trip |
| uvn_hi_i | input | 1 | High-side negative supply above trip |
| hi_stat_i | input | 1 | Returned high-side fault status bit |
| gate_lo_o | output | 1 | Low-side gate enable |
| gate_hi_o | output | 1 | High-side gate enable |
| flt_pull_o | output | 1 | 1 = pull the shared active-low fault line low |

## Verification
The assertions treat every input as already synchronised. They relate only the synchronised command, sense and supply values to the registered gate and fault outputs. They therefore assume that each raw input is held long enough to pass cleanly through two flops. The stimulus meets this assumption by changing inputs only at falling clock edges and holding each value for at least one full cycle. The random phase holds each input pattern for one to twelve cycles, so overlapping command edges, sense pulses inside and after blanking, and supply dips all appear.

// File: rtl/hb_pkg.sv
package hb_pkg;

    // One bit per bridge side
    typedef struct packed {
        logic hi;
        logic lo;
    } hb_pair_t;

    // Registered state held at the top of the controller
    typedef struct packed {
        hb_pair_t gate;
        hb_pair_t cmd_prev;
        logic     flt;
    } hb_top_state_t;

    // Bit positions inside the synchroniser bundle
    localparam int IDX_CMD  = 0;  // 0 lo, 1 hi
    localparam int IDX_OC   = 2;  // 2 lo, 3 hi
    localparam int IDX_UV   = 4;  // 4 lo pos, 5 lo neg, 6 hi pos, 7 hi neg
    localparam int IDX_STAT = 8;
    localparam int IN_W     = 9;

    // Supplies read as bad until synchronised values arrive
    localparam logic [IN_W-1:0] IN_RST = 9'h0F0;

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] chain_q [STAGES];
    logic [W-1:0] chain_d [STAGES];

    always_comb begin
        chain_d[0] = d_i;
        for (int k = 1; k < STAGES; k++) begin
            chain_d[k] = chain_q[k-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[g] <= RST_VAL;
                else        chain_q[g] <= chain_d[g];
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/hb_side.sv
module hb_side #(
    parameter int BLANK_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_i,     // synchronised command rising edge
    input  logic oc_i,       // synchronised sense flag
    input  logic uvp_i,      // positive supply low
    input  logic uvn_i,      // negative supply high
    input  logic gate_on_i,  // registered gate state of this side
    output logic fault_o,    // fault present for the coming cycle
    output logic uv_o,
    output logic sense_o,    // sense flag is honoured this cycle
    output logic oc_lat_o    // registered latch state
);
    localparam int CW = $clog2(BLANK_CYC + 2);
    localparam logic [CW-1:0] BLANK_LD = CW'(BLANK_CYC);

    typedef struct packed {
        logic          oc_lat;
        logic [CW-1:0] blank;
    } side_state_t;

    side_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        sense_o = gate_on_i && (st_q.blank == '0);
        uv_o    = uvp_i || uvn_i;
        if (rise_i) begin
            // new cycle: release the latch and restart blanking
            st_d.oc_lat = 1'b0;
            st_d.blank  = BLANK_LD;
        end else begin
            if (st_q.blank != '0) st_d.blank = st_q.blank - 1'b1;
            if (sense_o && oc_i)  st_d.oc_lat = 1'b1;
        end
        fault_o = uv_o || st_d.oc_lat;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign oc_lat_o = st_q.oc_lat;
endmodule

// File: rtl/hb_gate_guard.sv
module hb_gate_guard
    import hb_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int BLANK_CYC    = 8,
    parameter int TRIP_MAX_CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_lo_i,
    input  logic cmd_hi_i,
    input  logic oc_lo_i,
    input  logic oc_hi_i,
    input  logic uvp_lo_i,
    input  logic uvn_lo_i,
    input  logic uvp_hi_i,
    input  logic uvn_hi_i,
    input  logic hi_stat_i,
    output logic gate_lo_o,
    output logic gate_hi_o,
    output logic flt_pull_o
);
    // sense-to-gate latency: synchroniser depth plus the gate register
    localparam int TRIP_LAT = SYNC_STAGES + 1;

    generate
        if (TRIP_LAT > TRIP_MAX_CYC) begin : g_bad_trip
            $error("trip latency exceeds TRIP_MAX_CYC");
        end
    endgenerate

    logic [IN_W-1:0] raw_in, syn;
    logic [1:0] cmd_s, oc_s, rise, fault, uv_s, sense, oc_lat, gate_now;
    logic       stat_s;

    hb_top_state_t st_d, st_q;

    assign raw_in = {hi_stat_i, uvn_hi_i, uvp_hi_i, uvn_lo_i, uvp_lo_i,
                     oc_hi_i, oc_lo_i, cmd_hi_i, cmd_lo_i};

    hb_sync #(
        .W       (IN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (IN_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_in),
        .q_o   (syn)
    );

    assign cmd_s    = syn[IDX_CMD+1:IDX_CMD];
    assign oc_s     = syn[IDX_OC+1:IDX_OC];
    assign stat_s   = syn[IDX_STAT];
    assign gate_now = {st_q.gate.hi, st_q.gate.lo};
    assign rise     = cmd_s & ~{st_q.cmd_prev.hi, st_q.cmd_prev.lo};

    generate
        for (genvar s = 0; s < 2; s++) begin : g_side
            hb_side #(
                .BLANK_CYC (BLANK_CYC)
            ) u_side (
                .clk       (clk),
                .rst_n     (rst_n),
                .rise_i    (rise[s]),
                .oc_i      (oc_s[s]),
                .uvp_i     (syn[IDX_UV + 2*s]),
                .uvn_i     (syn[IDX_UV + 2*s + 1]),
                .gate_on_i (gate_now[s]),
                .fault_o   (fault[s]),
                .uv_o      (uv_s[s]),
                .sense_o   (sense[s]),
                .oc_lat_o  (oc_lat[s])
            );
        end
    endgenerate

    always_comb begin
        logic want_lo, want_hi;
        st_d = st_q;
        want_lo = cmd_s[0] && !fault[0];
        want_hi = cmd_s[1] && !fault[1];
        // interlock: turning on needs the opposite command low,
        // staying on does not
        st_d.gate.lo     = want_lo && (st_q.gate.lo || !cmd_s[1]);
        st_d.gate.hi     = want_hi && (st_q.gate.hi || !cmd_s[0]);
        st_d.cmd_prev.lo = cmd_s[0];
        st_d.cmd_prev.hi = cmd_s[1];
        st_d.flt         = fault[0] || fault[1] || stat_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.flt <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign gate_lo_o  = st_q.gate.lo;
    assign gate_hi_o  = st_q.gate.hi;
    assign flt_pull_o = st_q.flt;
endmodule

// File: rtl/hb_gate_guard_chk.sv
module hb_gate_guard_chk #(
    parameter int BLANK_CYC = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       gate_lo,
    input logic       gate_hi,
    input logic       flt,
    input logic [1:0] cmd_s,
    input logic [1:0] rise,
    input logic [1:0] oc_s,
    input logic [1:0] uv_s,
    input logic [1:0] sense,
    input logic [1:0] oc_lat,
    input logic       stat_s
);
    assert_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_s[0] |=> !gate_lo);

    assert_trip_lo_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sense[0] && oc_s[0] && !rise[0]) |=> (!gate_lo && flt));

    assert_trip_hi_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sense[1] && oc_s[1] && !rise[1]) |=> (!gate_hi && flt));

    assert_ignore_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sense[0] && !oc_lat[0]) |=> !oc_lat[0]);

    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oc_lat[1]) |-> $past(rise[1]));

    generate
        if (BLANK_CYC > 0) begin : g_blank
            assert_blank_R5: assert property (@(posedge clk) disable iff (!rst_n)
                rise[0] |=> !sense[0]);
        end
    endgenerate

    assert_clrfirst_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rise[0] |=> !oc_lat[0]);

    assert_uv_R7: assert property (@(posedge clk) disable iff (!rst_n)
        uv_s[1] |=> (!gate_hi && flt));

    assert_stat_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stat_s |=> flt);

    assert_lock_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_hi) |-> !$past(cmd_s[0]));

    assert_pair_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rise[0] && rise[1]) |=> (!gate_lo && !gate_hi));

    assert_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_lo && gate_hi));
endmodule

bind hb_gate_guard hb_gate_guard_chk #(
    .BLANK_CYC (BLANK_CYC)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .gate_lo (gate_lo_o),
    .gate_hi (gate_hi_o),
    .flt     (flt_pull_o),
    .cmd_s   (cmd_s),
    .rise    (rise),
    .oc_s    (oc_s),
    .uv_s    (uv_s),
    .sense   (sense),
    .oc_lat  (oc_lat),
    .stat_s  (stat_s)
);

// File: tb/hb_gate_guard_bench.sv
module hb_gate_guard_bench;
    localparam int BLANK = 4;
    localparam int TRIP  = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic cmd_lo = 0, cmd_hi = 0, oc_lo = 0, oc_hi = 0, stat = 0;
    logic uvp_lo = 1, uvn_lo = 1, uvp_hi = 1, uvn_hi = 1;
    logic gl, gh, fp;

    int    total = 0;
    int    bad = 0;
    string cur_req = "R8";
    bit    done = 0;

    hb_gate_guard #(
        .SYNC_STAGES  (2),
        .BLANK_CYC    (BLANK),
        .TRIP_MAX_CYC (TRIP)
    ) u_hb_gate_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_lo_i   (cmd_lo),
        .cmd_hi_i   (cmd_hi),
        .oc_lo_i    (oc_lo),
        .oc_hi_i    (oc_hi),
        .uvp_lo_i   (uvp_lo),
        .uvn_lo_i   (uvn_lo),
        .uvp_hi_i   (uvp_hi),
        .uvn_hi_i   (uvn_hi),
        .hi_stat_i  (stat),
        .gate_lo_o  (gl),
        .gate_hi_o  (gh),
        .flt_pull_o (fp)
    );

    // ---------------- reference model ----------------
    logic [8:0] pipe [$];
    bit m_prev [2];
    bit m_lat  [2];
    int m_blank[2];
    bit m_g    [2];
    bit m_flt;

    always @(posedge clk) begin
        if (!rst_n) begin
            pipe = '{9'h0F0, 9'h0F0};
            for (int i = 0; i < 2; i++) begin
                m_prev[i] = 0; m_lat[i] = 0; m_blank[i] = 0; m_g[i] = 0;
            end
            m_flt = 1;
        end else begin
            logic [8:0] s;
            bit c [2];
            bit f [2];
            bit nl, nh;
            s = pipe[0];
            void'(pipe.pop_front());
            pipe.push_back({stat, uvn_hi, uvp_hi, uvn_lo, uvp_lo,
                            oc_hi, oc_lo, cmd_hi, cmd_lo});
            for (int i = 0; i < 2; i++) begin
                c[i] = s[i];
                if (c[i] && !m_prev[i]) begin
                    m_lat[i] = 0;
                    m_blank[i] = BLANK;
                end else begin
                    if (m_g[i] && m_blank[i] == 0 && s[2+i]) m_lat[i] = 1;
                    if (m_blank[i] > 0) m_blank[i] = m_blank[i] - 1;
                end
                f[i] = m_lat[i] || s[4+2*i] || s[5+2*i];
                m_prev[i] = c[i];
            end
            nl = c[0] && !f[0] && (m_g[0] || !c[1]);
            nh = c[1] && !f[1] && (m_g[1] || !c[0]);
            m_g[0] = nl;
            m_g[1] = nh;
            m_flt = f[0] || f[1] || s[8];
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            total++;
            if ({gl, gh, fp} !== {m_g[0], m_g[1], m_flt}) begin
                bad++;
                $display("FAIL %s model compare t=%0t act=%b%b%b exp=%b%b%b",
                         cur_req, $time, gl, gh, fp, m_g[0], m_g[1], m_flt);
            end
            total++;
            if (gl && gh) begin
                bad++;
                $display("FAIL R12 both gates on act=11 exp=not 11");
            end
        end
    end

    task automatic chk(input logic act, input logic exp, input string req,
                       input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%b exp=%b", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic report();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        report();
    end

    initial begin
        int n;
        tick(3);
        rst_n = 1'b1;
        // R8: reset state and start-up hold
        chk(gl, 0, "R8", "low gate at reset");
        chk(gh, 0, "R8", "high gate at reset");
        chk(fp, 1, "R8", "fault at reset");
        cmd_lo = 1; tick(8);
        chk(gl, 0, "R8", "gate held with supplies bad");
        uvp_lo = 0; uvn_lo = 0; uvp_hi = 0; uvn_hi = 0; tick(6);
        chk(gl, 1, "R8", "gate on once supplies good");
        chk(fp, 0, "R8", "fault released");

        cur_req = "R1";
        cmd_lo = 0; tick(5);
        chk(gl, 0, "R1", "low gate follows low");
        cmd_hi = 1; tick(5);
        chk(gh, 1, "R1", "high gate follows high");
        cmd_hi = 0; tick(5);
        chk(gh, 0, "R1", "high gate follows low");

        cur_req = "R7";
        cmd_hi = 1; tick(5);
        uvn_hi = 1; tick(5);
        chk(gh, 0, "R7", "neg supply fault holds high off");
        chk(fp, 1, "R7", "neg supply fault flagged");
        uvn_hi = 0; tick(5);
        chk(gh, 1, "R7", "high gate back without edge");
        chk(fp, 0, "R7", "fault cleared");
        cmd_hi = 0; tick(4);
        cmd_lo = 1; tick(6);
        uvp_lo = 1; tick(5);
        chk(gl, 0, "R7", "pos supply fault holds low off");
        uvp_lo = 0; tick(5);
        chk(gl, 1, "R7", "low gate back without edge");

        cur_req = "R2";
        oc_lo = 1; n = 0;
        while (gl && n < 20) begin tick(1); n++; end
        chk(n <= TRIP, 1, "R2", "trip within limit");
        chk(gl, 0, "R2", "low gate tripped");
        chk(fp, 1, "R2", "trip flagged");

        cur_req = "R4";
        oc_lo = 0; tick(8);
        chk(gl, 0, "R4", "latched after flag clears");
        chk(fp, 1, "R4", "fault held after flag clears");
        cmd_lo = 0; tick(4);
        chk(fp, 1, "R4", "falling command does not clear");
        cmd_lo = 1; tick(6);
        chk(gl, 1, "R4", "rising command clears");
        chk(fp, 0, "R4", "fault released on rise");

        cur_req = "R3";
        cmd_lo = 0; tick(5);
        oc_lo = 1; tick(8);
        chk(fp, 0, "R3", "flag ignored with gate off");
        chk(gl, 0, "R3", "gate stays off");
        oc_lo = 0; tick(4);

        cur_req = "R5";
        cmd_lo = 1; tick(1);
        oc_lo = 1; tick(1);
        oc_lo = 0; tick(6);
        chk(gl, 1, "R5", "pulse in blanking ignored");
        chk(fp, 0, "R5", "no fault from blanked pulse");

        cur_req = "R6";
        cmd_lo = 0; tick(5);
        cmd_lo = 1; oc_lo = 1; tick(3);
        chk(gl, 1, "R6", "gate on despite flag at rise");
        tick(8);
        chk(gl, 0, "R6", "trip after blanking");
        oc_lo = 0; cmd_lo = 0; tick(4);

        cur_req = "R10";
        cmd_lo = 1; tick(6);
        cmd_hi = 1; tick(5);
        chk(gh, 0, "R10", "high blocked by low command");
        chk(gl, 1, "R10", "low stays on");
        cmd_lo = 0; tick(5);
        chk(gl, 0, "R10", "low off");
        chk(gh, 1, "R10", "high on after low released");
        cmd_hi = 0; tick(4);

        cur_req = "R11";
        cmd_lo = 1; cmd_hi = 1; tick(6);
        chk(gl, 0, "R11", "low off on joint rise");
        chk(gh, 0, "R11", "high off on joint rise");
        cmd_hi = 0; tick(5);
        chk(gl, 1, "R11", "low on after high falls");
        cmd_lo = 0; tick(4);

        cur_req = "R9";
        cmd_lo = 1; tick(6);
        stat = 1; tick(5);
        chk(fp, 1, "R9", "status bit flags fault");
        chk(gl, 1, "R9", "status bit spares low gate");
        stat = 0; tick(5);
        chk(fp, 0, "R9", "status cleared");
        uvp_hi = 1; tick(5);
        chk(fp, 1, "R9", "high supply fault flagged");
        chk(gl, 1, "R9", "high fault spares low gate");
        uvp_hi = 0; cmd_lo = 0; tick(5);

        cur_req = "R12";
        for (int it = 0; it < 400; it++) begin
            logic [31:0] r;
            r = $urandom();
            cmd_lo = r[0]; cmd_hi = r[1]; oc_lo = r[2] & r[3];
            oc_hi = r[4] & r[5]; stat = (r[7:6] == 2'b11);
            uvp_lo = (r[11:8] == 4'hF); uvn_lo = (r[15:12] == 4'hF);
            uvp_hi = (r[19:16] == 4'hF); uvn_hi = (r[23:20] == 4'hF);
            tick(1 + int'(r[27:24] % 12));
        end
        tick(5);
        report();
    end
endmodule